// File: doc/BRIEF.md
# Priority Interrupt Controller with Timed Disable

This block arbitrates interrupt requests for a small 16-bit processor core. It holds, for each user source, a pending flag, an enable bit and a 3-bit priority. It also has a separate bank of trap inputs whose latched status can never be switched off. Every cycle it picks the most urgent request that beats the current CPU priority level, and it presents that request's vector number and level to the core from a register.

When the core acknowledges a request, the controller saves the running CPU level on an internal stack and raises the level to that of the accepted request. A return strobe pops the saved level back. Software reaches the block through a single-cycle register write port. Through that port it can load a countdown that silences user levels 1 to 6 for a fixed number of cycles, and it can set a bit that stops any user interrupt from pre-empting one already in service. A separate strobe lets software set the CPU level directly to a value from 0 to 7.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every user priority reads as level 4, all flags, enables and trap status bits are clear, the CPU level is 0, no request is presented and the error output is low.
- R2: A user source requests only when its flag and enable are both set and its priority is strictly greater than the CPU level. A priority of 0 therefore never requests.
- R3: The presented request has the highest level among the eligible candidates. Among user sources at equal level the lowest index wins. A user source i gets vector N_TRAP+i, and trap t gets vector t and level 8+t.
- R4: A high trap input latches its status bit. The bit stays set until a 1 is written to its bit at the trap-clear address (2). While set it requests, and a CPU level written by software (at most 7) never blocks it.
- R5: Writing a count to the hold address (4) starts a countdown that drops by one each cycle. While the count is nonzero, user levels 1 to 6 are blocked; level 7 and traps still pass. The countdown lasts exactly as many cycles as the value written.
- R6: While bit 0 of the control address (3) is set and the stack is not empty, no user request is presented, whatever its level; traps still pass.
- R7: An acknowledge while a request is presented pushes the CPU level and sets the CPU level to the presented level. An acknowledge while no request is presented has no effect.
- R8: Acknowledge does not clear the source flag. A return restores the saved level, so a source whose flag is still set is presented again.
- R9: The stack holds DEPTH levels. An acknowledge with a full stack, or a return with an empty one, pulses the error output for one cycle. An overflowing acknowledge still raises the level but saves nothing. An underflowing return leaves the level unchanged.
- R10: Flags are set by the irq_i pulse inputs or by a full write to address 0. A request appears one cycle after the flag, enable or priority register changes. It is withdrawn for the cycle after an accepted acknowledge, a return or a CPU level write.
- R11: A CPU level write sets the CPU level to the 3-bit value given, and arbitration uses the new level from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: 0 flags, 1 enables, 2 trap clear, 3 control, 4 hold count, 8+i priority of source i |
| wr_data_i | input | DATA_W | Write data |
| irq_i | input | N_SRC | Per-source flag set pulses |
| trap_i | input | N_TRAP | Trap condition inputs |
| cpu_lvl_we_i | input | 1 | CPU level write strobe |
| cpu_lvl_i | input | 3 | New CPU level |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ret_i | input | 1 | Return-from-interrupt strobe |
| req_o | output | 1 | Request presented |
| vec_o | output | VEC_W | Vector number of the presented request |
| lvl_o | output | 4 | Level of the presented request |
| cur_lvl_o | output | 4 | Current CPU level |
| stk_err_o | output | 1 | Stack overflow or underflow pulse |

## Verification
Several properties are checked on every cycle. A presented request always has a level above the CPU level. A request at level 1 to 6 never follows an active hold count. A user request never follows an active nesting block. The stack depth stays bounded, trap inputs are latched, and accepted or ignored acknowledges have their stated effect on the level. Other behaviour can only be shown by the bench scenarios: the winner and vector chosen among many candidates, the reset value of the priorities, the exact length of the countdown, a flagged source being taken again after return, and the order of levels popped across a full stack and beyond it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t       LVL_TRAP_BASE = 4'd8;
  localparam logic [2:0] PRIO_RST      = 3'd4;

  localparam int ADR_FLAG      = 0;
  localparam int ADR_ENA       = 1;
  localparam int ADR_TRAP_CLR  = 2;
  localparam int ADR_CTRL      = 3;
  localparam int ADR_HOLD      = 4;
  localparam int ADR_PRIO_BASE = 8;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [N_SRC-1:0]        irq_i,
  input  logic [N_TRAP-1:0]       trap_i,
  output logic [N_SRC-1:0]        flag_o,
  output logic [N_SRC-1:0]        ena_o,
  output logic [N_SRC-1:0][2:0]   prio_o,
  output logic [N_TRAP-1:0]       trap_st_o,
  output logic                    nest_dis_o,
  output logic                    hold_act_o
);
  logic [N_SRC-1:0]  flag_q, ena_q;
  logic [N_TRAP-1:0] trap_q;
  logic              nest_q;
  logic [CNT_W-1:0]  hold_q;
  logic [2:0]        prio_q [N_SRC];

  logic wr_flag, wr_ena, wr_tclr, wr_ctrl, wr_hold;
  assign wr_flag = wr_en_i && (wr_addr_i == ADDR_W'(ADR_FLAG));
  assign wr_ena  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_ENA));
  assign wr_tclr = wr_en_i && (wr_addr_i == ADDR_W'(ADR_TRAP_CLR));
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
  assign wr_hold = wr_en_i && (wr_addr_i == ADDR_W'(ADR_HOLD));

  wire unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      ena_q  <= '0;
      trap_q <= '0;
      nest_q <= 1'b0;
    end else begin
      flag_q <= (wr_flag ? wr_data_i[N_SRC-1:0] : flag_q) | irq_i;
      if (wr_ena) ena_q <= wr_data_i[N_SRC-1:0];
      // a new trap condition wins over a clear in the same cycle
      trap_q <= (trap_q & ~(wr_tclr ? wr_data_i[N_TRAP-1:0] : '0)) | trap_i;
      if (wr_ctrl) nest_q <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hold_q <= '0;
    else if (wr_hold)       hold_q <= wr_data_i[CNT_W-1:0];
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    localparam logic [ADDR_W-1:0] PADR = ADDR_W'(ADR_PRIO_BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               prio_q[g] <= PRIO_RST;
      else if (wr_en_i && (wr_addr_i == PADR))   prio_q[g] <= wr_data_i[2:0];
    end
    assign prio_o[g] = prio_q[g];
  end

  assign flag_o     = flag_q;
  assign ena_o      = ena_q;
  assign trap_st_o  = trap_q;
  assign nest_dis_o = nest_q;
  assign hold_act_o = (hold_q != '0);

  assert_trap_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trap_i) |=> ((trap_q & $past(trap_i)) == $past(trap_i)));

  assert_hold_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0 && !wr_hold) |=> (hold_q == $past(hold_q) - 1'b1));
endmodule

// File: rtl/pic_arb.sv
module pic_arb
  import pic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int VEC_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      flag_i,
  input  logic [N_SRC-1:0]      ena_i,
  input  logic [N_SRC-1:0][2:0] prio_i,
  input  logic [N_TRAP-1:0]     trap_st_i,
  input  lvl_t                  cur_lvl_i,
  input  logic                  hold_act_i,
  input  logic                  nest_blk_i,
  input  logic                  flush_i,
  output logic                  req_o,
  output logic [VEC_W-1:0]      vec_o,
  output lvl_t                  lvl_o
);
  lvl_t             win_lvl;
  logic [VEC_W-1:0] win_vec;

  always_comb begin
    lvl_t cand;
    cand    = '0;
    win_lvl = '0;
    win_vec = '0;
    // trap levels rise with index, so a later trap beats an earlier one
    for (int t = 0; t < N_TRAP; t++) begin
      cand = LVL_TRAP_BASE + lvl_t'(t);
      if (trap_st_i[t] && cand > cur_lvl_i && cand > win_lvl) begin
        win_lvl = cand;
        win_vec = VEC_W'(t);
      end
    end
    // strict compare keeps the lowest index on a tie
    for (int s = 0; s < N_SRC; s++) begin
      cand = {1'b0, prio_i[s]};
      if (flag_i[s] && ena_i[s] && !nest_blk_i &&
          !(hold_act_i && cand >= 4'd1 && cand <= 4'd6) &&
          cand > cur_lvl_i && cand > win_lvl) begin
        win_lvl = cand;
        win_vec = VEC_W'(N_TRAP + s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      vec_o <= '0;
      lvl_o <= '0;
    end else if (flush_i) begin
      req_o <= 1'b0;
    end else begin
      req_o <= (win_lvl != '0);
      vec_o <= win_vec;
      lvl_o <= win_lvl;
    end
  end

  assert_hold_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && lvl_o >= 4'd1 && lvl_o <= 4'd6) |-> !$past(hold_act_i));

  assert_nest_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && lvl_o < LVL_TRAP_BASE) |-> !$past(nest_blk_i));

  assert_no_prio_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (lvl_o != '0));
endmodule

// File: rtl/pic_lvl_stack.sv
module pic_lvl_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_i,
  input  lvl_t       ack_lvl_i,
  input  logic       ret_i,
  input  logic       cpu_we_i,
  input  logic [2:0] cpu_lvl_i,
  output lvl_t       cur_lvl_o,
  output logic       depth_nz_o,
  output logic       err_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t             mem_q [DEPTH];
  logic [PTR_W-1:0] depth_q, top_ptr;
  lvl_t             cur_q;
  logic             err_q, full, empty;

  assign full    = (depth_q == PTR_W'(DEPTH));
  assign empty   = (depth_q == '0);
  assign top_ptr = depth_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      cur_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (ack_i) begin
        cur_q <= ack_lvl_i;
        if (full) err_q   <= 1'b1;
        else      depth_q <= depth_q + 1'b1;
      end else if (ret_i) begin
        if (empty) begin
          err_q <= 1'b1;
        end else begin
          depth_q <= top_ptr;
          cur_q   <= mem_q[top_ptr[IDX_W-1:0]];
        end
      end else if (cpu_we_i) begin
        cur_q <= {1'b0, cpu_lvl_i};
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ack_i && !full) mem_q[depth_q[IDX_W-1:0]] <= cur_q;
  end

  assign cur_lvl_o  = cur_q;
  assign depth_nz_o = !empty;
  assign err_o      = err_q;

  assert_depth_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= PTR_W'(DEPTH));

  assert_ack_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (cur_q == $past(ack_lvl_i)));

  assert_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !ack_i && empty) |=> (err_q && cur_q == $past(cur_q)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 8,
  parameter int VEC_W  = $clog2(N_SRC + N_TRAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [N_TRAP-1:0] trap_i,
  input  logic              cpu_lvl_we_i,
  input  logic [2:0]        cpu_lvl_i,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [3:0]        lvl_o,
  output logic [3:0]        cur_lvl_o,
  output logic              stk_err_o
);
  logic [N_SRC-1:0]      flag, ena;
  logic [N_SRC-1:0][2:0] prio;
  logic [N_TRAP-1:0]     trap_st;
  logic                  nest_dis, hold_act, depth_nz;
  logic                  ack_ok, flush, req_q;
  lvl_t                  lvl_q, cur_lvl;

  assign ack_ok = ack_i && req_q;
  assign flush  = ack_ok || ret_i || cpu_lvl_we_i;

  pic_regs #(
    .N_SRC(N_SRC), .N_TRAP(N_TRAP), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .irq_i      (irq_i),
    .trap_i     (trap_i),
    .flag_o     (flag),
    .ena_o      (ena),
    .prio_o     (prio),
    .trap_st_o  (trap_st),
    .nest_dis_o (nest_dis),
    .hold_act_o (hold_act)
  );

  pic_arb #(
    .N_SRC(N_SRC), .N_TRAP(N_TRAP), .VEC_W(VEC_W)
  ) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_i     (flag),
    .ena_i      (ena),
    .prio_i     (prio),
    .trap_st_i  (trap_st),
    .cur_lvl_i  (cur_lvl),
    .hold_act_i (hold_act),
    .nest_blk_i (nest_dis && depth_nz),
    .flush_i    (flush),
    .req_o      (req_q),
    .vec_o      (vec_o),
    .lvl_o      (lvl_q)
  );

  pic_lvl_stack #(
    .DEPTH(DEPTH)
  ) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ack_i      (ack_ok),
    .ack_lvl_i  (lvl_q),
    .ret_i      (ret_i),
    .cpu_we_i   (cpu_lvl_we_i),
    .cpu_lvl_i  (cpu_lvl_i),
    .cur_lvl_o  (cur_lvl),
    .depth_nz_o (depth_nz),
    .err_o      (stk_err_o)
  );

  assign req_o     = req_q;
  assign lvl_o     = lvl_q;
  assign cur_lvl_o = cur_lvl;

  assert_above_cpu_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (lvl_o > cur_lvl_o));

  assert_ack_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && !ret_i && !cpu_lvl_we_i) |=> $stable(cur_lvl_o));

  assert_cpu_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_lvl_we_i && !ack_ok && !ret_i) |=> (cur_lvl_o == {1'b0, $past(cpu_lvl_i)}));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  localparam int A_FLAG = 0, A_ENA = 1, A_TCLR = 2, A_CTRL = 3, A_HOLD = 4, A_PRIO = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] irq = '0;
  logic [3:0] trap = '0;
  logic       cpu_we = 1'b0;
  logic [2:0] cpu_lvl = '0;
  logic       ack = 1'b0;
  logic       ret = 1'b0;
  logic       req;
  logic [3:0] vec, lvl, cur_lvl;
  logic       err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_i(irq), .trap_i(trap), .cpu_lvl_we_i(cpu_we), .cpu_lvl_i(cpu_lvl),
    .ack_i(ack), .ret_i(ret), .req_o(req), .vec_o(vec), .lvl_o(lvl),
    .cur_lvl_o(cur_lvl), .stk_err_o(err)
  );

  function automatic int code(input int l, input int v);
    return 1024 + l * 32 + v;
  endfunction

  function automatic int got();
    return req ? 1024 + int'(lvl) * 32 + int'(vec) : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cpu(input int l);
    cpu_we = 1'b1; cpu_lvl = 3'(l);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; @(negedge clk); ret = 1'b0;
  endtask

  task automatic pulse_trap(input int v);
    trap = 4'(v); @(negedge clk); trap = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state, default priority 4; R10 one-cycle latency from irq pulse
    do_reset();
    chk("R1 req after reset", got(), 0);
    chk("R1 cpu level after reset", int'(cur_lvl), 0);
    chk("R1 err after reset", int'(err), 0);
    wr(A_ENA, 8'h08);
    tick(1);
    chk("R2 enable without flag", got(), 0);
    irq = 8'h08; @(negedge clk); irq = '0;
    chk("R10 request not yet visible", got(), 0);
    tick(1);
    chk("R1 default level 4 vector 7", got(), code(4, 7));

    // R2/R11 sweep priority against CPU level
    do_reset();
    wr(A_ENA, 1); wr(A_FLAG, 1);
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 8; c++) begin
        wr(A_PRIO, p);
        set_cpu(c);
        chk("R11 cpu level written", int'(cur_lvl), c);
        tick(1);
        chk("R2 strict level compare", got(), (p > c) ? code(p, 4) : 0);
      end
    end

    // R3 tie and order sweep over source pairs
    do_reset();
    wr(A_ENA, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        wr(A_FLAG, (1 << i) | (1 << j));
        tick(1);
        chk("R3 tie lowest index", got(), code(4, 4 + i));
        wr(A_PRIO + j, 6);
        tick(1);
        chk("R3 higher level wins", got(), code(6, 4 + j));
        wr(A_PRIO + j, 4);
      end
    end

    // R4 traps latch, stack by index, pass CPU level 7, clear by write-1
    do_reset();
    wr(A_ENA, 1); wr(A_FLAG, 1); wr(A_PRIO, 7);
    set_cpu(7);
    tick(1);
    chk("R2 level 7 blocked at cpu 7", got(), 0);
    for (int k = 0; k < 4; k++) begin
      pulse_trap(1 << k);
      tick(1);
      chk("R4 trap latched and wins", got(), code(8 + k, k));
    end
    for (int k = 3; k >= 0; k--) begin
      wr(A_TCLR, 1 << k);
      tick(1);
      chk("R4 trap clear by write-1", got(), (k > 0) ? code(7 + k, k - 1) : 0);
    end

    // R5 timed hold masks levels 1..6 only
    do_reset();
    wr(A_ENA, 1); wr(A_FLAG, 1);
    for (int p = 1; p < 8; p++) begin
      wr(A_PRIO, p);
      wr(A_HOLD, 50);
      tick(2);
      chk("R5 hold masks 1..6", got(), (p == 7) ? code(7, 4) : 0);
      wr(A_HOLD, 0);
      tick(1);
      chk("R5 hold released", got(), code(p, 4));
    end
    wr(A_PRIO, 3);
    wr(A_HOLD, 50);
    pulse_trap(1);
    tick(1);
    chk("R5 trap passes hold", got(), code(8, 0));
    wr(A_TCLR, 1);
    wr(A_HOLD, 5);
    tick(5);
    chk("R5 hold still active at count end", got(), 0);
    tick(1);
    chk("R5 hold expired on time", got(), code(3, 4));

    // R6 nesting disable
    do_reset();
    wr(A_CTRL, 1); wr(A_ENA, 3); wr(A_PRIO, 2); wr(A_PRIO + 1, 6); wr(A_FLAG, 1);
    tick(1);
    chk("R6 first request", got(), code(2, 4));
    do_ack();
    chk("R7 level raised", int'(cur_lvl), 2);
    wr(A_FLAG, 3);
    tick(1);
    chk("R6 no pre-emption", got(), 0);
    pulse_trap(1);
    tick(1);
    chk("R6 trap still pre-empts", got(), code(8, 0));
    wr(A_TCLR, 1);
    tick(1);
    chk("R6 blocked again after trap clear", got(), 0);
    wr(A_CTRL, 0);
    tick(1);
    chk("R6 nesting allowed", got(), code(6, 5));

    // R7/R8 ack keeps flag, return retakes
    do_reset();
    wr(A_ENA, 1); wr(A_FLAG, 1);
    tick(1);
    chk("R7 request before ack", got(), code(4, 4));
    do_ack();
    chk("R7 cpu level after ack", int'(cur_lvl), 4);
    chk("R10 request withdrawn after ack", got(), 0);
    tick(1);
    chk("R7 same level not re-taken", got(), 0);
    do_ack();
    chk("R7 ignored ack keeps level", int'(cur_lvl), 4);
    do_ret();
    chk("R8 level restored", int'(cur_lvl), 0);
    tick(1);
    chk("R8 flagged source retaken", got(), code(4, 4));
    do_ack();
    wr(A_FLAG, 0);
    do_ret();
    tick(1);
    chk("R8 cleared flag not retaken", got(), 0);

    // R9 fill stack, overflow, drain, underflow
    do_reset();
    wr(A_FLAG, 8'hFF);
    for (int i = 0; i < 7; i++) wr(A_PRIO + i, i + 1);
    for (int k = 1; k < 8; k++) begin
      wr(A_ENA, (1 << k) - 1);
      tick(1);
      chk("R9 climb request", got(), code(k, 3 + k));
      do_ack();
      chk("R9 climb level", int'(cur_lvl), k);
      chk("R9 no error while filling", int'(err), 0);
    end
    pulse_trap(1);
    tick(1);
    chk("R9 trap 0 request", got(), code(8, 0));
    do_ack();
    chk("R9 stack full no error", int'(err), 0);
    pulse_trap(2);
    tick(1);
    chk("R9 trap 1 request", got(), code(9, 1));
    do_ack();
    chk("R9 overflow error", int'(err), 1);
    chk("R9 overflow still raises level", int'(cur_lvl), 9);
    tick(1);
    chk("R9 error is a pulse", int'(err), 0);
    for (int k = 7; k >= 0; k--) begin
      do_ret();
      chk("R9 popped level", int'(cur_lvl), k);
      chk("R9 no error while draining", int'(err), 0);
    end
    do_ret();
    chk("R9 underflow error", int'(err), 1);
    chk("R9 underflow keeps level", int'(cur_lvl), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule